// File: doc/BRIEF.md
# Register Mask Integrity Checker

This block is a hardware sequencer that exercises a bank of 16-bit registers through a simple synchronous register bus. Each register is described by a table entry: an offset, a mask of bits that must never move (read-only), and a mask of bits that must follow what is written (read/write). Bits outside both masks are not examined. For every entry the sequencer first reads and keeps the register's present value. It then writes all zeros and reads back, writes all ones and reads back, and finally writes the kept value back so the test leaves the bank as it found it.

The table is a small constant ROM inside the block. It holds fifteen entries and is walked in ascending offset order. Each entry below is given as offset:read-only/read-write:
0x00:0000/7180, 0x02:ffff/0000, 0x03:ffff/0000, 0x04:0000/ffff, 0x05:efff/0000, 0x06:0001/0000, 0x07:0800/b7ff, 0x08:ffff/0000, 0x09:0000/ff00, 0x0a:7c00/0000, 0x10:0000/ffbf, 0x11:3300/0000, 0x19:001f/0000, 0x1e:0000/ffff, 0x1f:0000/ffff.

The bus has no back-pressure. A read strobe is a one-cycle pulse, and the target must present the read data exactly `RD_LAT` cycles later; it cannot stall. Writes complete in the cycle they are issued. A one-cycle `start` pulse launches a run. When the run ends, `done` and `pass` report the outcome. On a failure, the offset, the lowest offending bit and a 2-bit error code are also reported.

Top module: `regchk_top`

## Requirements
- R1: After reset `busy`, `done` and `pass` are 0; a `start` pulse while idle makes `busy` 1 and `done` 0 from the next cycle.
- R2: For each entry, in table order, the bus carries exactly: read offset, write 0x0000, read, write 0xffff, read, write of the first value read; `bus_we` and `bus_re` are never high together.
- R3: Read data is sampled exactly `RD_LAT` cycles after the cycle in which `bus_re` is high.
- R4: A read-only bit differing from its first-read value after the zero write gives code 0, after the ones write code 1; a read-only violation takes precedence over a read/write violation in the same readback.
- R5: A read/write bit reading 1 after the zero write gives code 2; a read/write bit reading 0 after the ones write gives code 3.
- R6: Bits outside both masks never cause a failure, whatever value they read.
- R7: The last write to every visited register, including the one that fails, restores its first-read value.
- R8: On the first failure, the run ends after that register's restore write with no further bus access; `fail_offset` holds the entry offset and `fail_bit` the lowest failing bit index of the reported class.
- R9: `done` and `pass` stay constant until the next `start`. `pass` is 1 only when every entry is clean, and `pass` is never 1 without `done`. The failure fields hold still while `done` is high.
- R10: A `start` pulse while `busy` is ignored; the access sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse launching a run |
| bus_addr | output | ADDR_W | Register offset on the bus |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | Write enable |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Read data, valid RD_LAT cycles after the strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | All entries clean, valid with done |
| fail_offset | output | ADDR_W | Offset of the failing entry |
| fail_bit | output | $clog2(DATA_W) | Lowest failing bit index |
| fail_code | output | 2 | Error class, 0 to 3 |

## Verification
The bench builds the block with `RD_LAT` set to 3 instead of the default 2. This places several idle cycles between each strobe and its sample, and the bench's register model returns junk on every cycle except the exact landing one. A sampling point off by even one cycle therefore turns into a wrong verdict. The 16-bit width and full fifteen-entry table are kept, so faults can be planted at early, middle and late entries. The stuck and writable bits are chosen to reach each of the four error classes, the read-only-over-read/write precedence, and the "neither mask" bits.

// File: rtl/regchk_pkg.sv
package regchk_pkg;

  localparam int TBL_DEPTH = 15;

  typedef enum logic [1:0] {
    ERR_RO_ZERO = 2'd0,
    ERR_RO_ONE  = 2'd1,
    ERR_RW_CLR  = 2'd2,
    ERR_RW_SET  = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    PH_ORIG = 2'd0,
    PH_ZERO = 2'd1,
    PH_ONE  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [7:0]  off;
    logic [15:0] ro;
    logic [15:0] rw;
  } entry_t;

  function automatic entry_t table_entry(input int idx);
    entry_t e;
    case (idx)
      0:  e = '{8'h00, 16'h0000, 16'h7180};
      1:  e = '{8'h02, 16'hffff, 16'h0000};
      2:  e = '{8'h03, 16'hffff, 16'h0000};
      3:  e = '{8'h04, 16'h0000, 16'hffff};
      4:  e = '{8'h05, 16'hefff, 16'h0000};
      5:  e = '{8'h06, 16'h0001, 16'h0000};
      6:  e = '{8'h07, 16'h0800, 16'hb7ff};
      7:  e = '{8'h08, 16'hffff, 16'h0000};
      8:  e = '{8'h09, 16'h0000, 16'hff00};
      9:  e = '{8'h0a, 16'h7c00, 16'h0000};
      10: e = '{8'h10, 16'h0000, 16'hffbf};
      11: e = '{8'h11, 16'h3300, 16'h0000};
      12: e = '{8'h19, 16'h001f, 16'h0000};
      13: e = '{8'h1e, 16'h0000, 16'hffff};
      14: e = '{8'h1f, 16'h0000, 16'hffff};
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/regchk_rom.sv
module regchk_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] off,
  output logic [DATA_W-1:0] ro_mask,
  output logic [DATA_W-1:0] rw_mask
);
  regchk_pkg::entry_t ent;

  always_comb begin
    ent     = regchk_pkg::table_entry(int'(idx));
    off     = ADDR_W'(ent.off);
    ro_mask = DATA_W'(ent.ro);
    rw_mask = DATA_W'(ent.rw);
  end
endmodule

// File: rtl/regchk_rdwait.sv
module regchk_rdwait #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic land
);
  logic [RD_LAT-1:0] inflight;

  generate
    if (RD_LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= issue;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= {inflight[RD_LAT-2:0], issue};
      end
    end
  endgenerate

  assign land = inflight[RD_LAT-1];

  // R3: a new strobe never overlaps a read still in flight
  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (inflight == '0));
endmodule

// File: rtl/regchk_judge.sv
module regchk_judge #(
  parameter int DATA_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] orig,
  input  logic [DATA_W-1:0] ro_mask,
  input  logic [DATA_W-1:0] rw_mask,
  input  logic              ones_phase,
  output logic              err,
  output logic [1:0]        code,
  output logic [BIT_W-1:0]  bitn
);
  import regchk_pkg::*;

  logic [DATA_W-1:0] ro_bad, rw_bad, vec;

  always_comb begin
    ro_bad = (rdata ^ orig) & ro_mask;
    rw_bad = ones_phase ? (~rdata & rw_mask) : (rdata & rw_mask);
    if (|ro_bad) begin
      vec  = ro_bad;
      code = ones_phase ? ERR_RO_ONE : ERR_RO_ZERO;
    end else begin
      vec  = rw_bad;
      code = ones_phase ? ERR_RW_SET : ERR_RW_CLR;
    end
    err  = |vec;
    bitn = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (vec[i]) bitn = BIT_W'(i);
  end
endmodule

// File: rtl/regchk_top.sv
module regchk_top #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int N_ENTRIES = 15,
  parameter int RD_LAT    = 2,
  localparam int BIT_W    = $clog2(DATA_W),
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_offset,
  output logic [BIT_W-1:0]  fail_bit,
  output logic [1:0]        fail_code
);
  import regchk_pkg::*;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WAIT, S_WRITE, S_RESTORE
  } state_e;

  state_e            state;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] orig;
  logic              failed;

  logic [ADDR_W-1:0] ent_off;
  logic [DATA_W-1:0] ent_ro, ent_rw;
  logic              land;
  logic              ev_err;
  logic [1:0]        ev_code;
  logic [BIT_W-1:0]  ev_bit;

  regchk_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rom (
    .idx(idx), .off(ent_off), .ro_mask(ent_ro), .rw_mask(ent_rw)
  );

  regchk_rdwait #(.RD_LAT(RD_LAT)) u_wait (
    .clk(clk), .rst_n(rst_n), .issue(bus_re), .land(land)
  );

  regchk_judge #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_judge (
    .rdata(bus_rdata), .orig(orig), .ro_mask(ent_ro), .rw_mask(ent_rw),
    .ones_phase(phase == PH_ONE), .err(ev_err), .code(ev_code), .bitn(ev_bit)
  );

  always_comb begin
    bus_addr  = ent_off;
    bus_re    = (state == S_READ);
    bus_we    = (state == S_WRITE) || (state == S_RESTORE);
    if (state == S_RESTORE)  bus_wdata = orig;
    else if (phase == PH_ONE) bus_wdata = '1;
    else                      bus_wdata = '0;
    busy      = (state != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      phase       <= PH_ORIG;
      idx         <= '0;
      orig        <= '0;
      failed      <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail_offset <= '0;
      fail_bit    <= '0;
      fail_code   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx         <= '0;
          phase       <= PH_ORIG;
          failed      <= 1'b0;
          done        <= 1'b0;
          pass        <= 1'b0;
          fail_offset <= '0;
          fail_bit    <= '0;
          fail_code   <= '0;
          state       <= S_READ;
        end
        S_READ:  state <= S_WAIT;
        S_WAIT: if (land) begin
          if (phase == PH_ORIG) begin
            orig  <= bus_rdata;
            phase <= PH_ZERO;
            state <= S_WRITE;
          end else if (ev_err) begin
            failed      <= 1'b1;
            fail_offset <= ent_off;
            fail_bit    <= ev_bit;
            fail_code   <= ev_code;
            state       <= S_RESTORE;
          end else if (phase == PH_ZERO) begin
            phase <= PH_ONE;
            state <= S_WRITE;
          end else begin
            state <= S_RESTORE;
          end
        end
        S_WRITE: state <= S_READ;
        S_RESTORE: begin
          if (failed || idx == IDX_W'(N_ENTRIES - 1)) begin
            done  <= 1'b1;
            pass  <= !failed;
            state <= S_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            phase <= PH_ORIG;
            state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_bus_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  p_pass_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_fail_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(fail_code) && $stable(fail_bit) && $stable(fail_offset)));

  p_restore_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_we));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy) |-> (!bus_we && !bus_re));
endmodule

// File: tb/regchk_top_test.sv
module regchk_top_test;
  localparam int DW = 16, AW = 8, NE = 15, LAT = 3, BW = 4;

  typedef struct { bit we; logic [7:0] a; logic [15:0] d; } op_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] bus_addr, fail_offset;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_we, bus_re, busy, done, pass;
  logic [BW-1:0] fail_bit;
  logic [1:0] fail_code;

  regchk_top #(.ADDR_W(AW), .DATA_W(DW), .N_ENTRIES(NE), .RD_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .pass(pass),
    .fail_offset(fail_offset), .fail_bit(fail_bit), .fail_code(fail_code)
  );

  int checks = 0, fails = 0;

  logic [7:0]  t_off[NE];
  logic [15:0] t_ro[NE], t_rw[NE];
  logic [15:0] cfg_val[32], cfg_wm[32];
  logic [15:0] bval[32], bwm[32];
  logic        load = 1'b0;
  logic        pv[LAT];
  logic [15:0] pd[LAT];
  op_t         q[$];
  bit          e_pass; logic [7:0] e_off; int e_bit; logic [1:0] e_code;

  // register bank model with fixed read latency; junk off the landing cycle
  always @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < 32; k++) begin bval[k] <= cfg_val[k]; bwm[k] <= cfg_wm[k]; end
      for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    end else begin
      if (bus_we) bval[bus_addr[4:0]] <= (bval[bus_addr[4:0]] & ~bwm[bus_addr[4:0]]) |
                                         (bus_wdata & bwm[bus_addr[4:0]]);
      pv[0] <= bus_re;
      pd[0] <= bval[bus_addr[4:0]];
      for (int k = 1; k < LAT; k++) begin pv[k] <= pv[k-1]; pd[k] <= pd[k-1]; end
    end
  end
  assign bus_rdata = pv[LAT-1] ? pd[LAT-1] : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every clock: compare each bus access with the predicted stream (R2, R7, R8)
  always @(negedge clk) begin
    if (rst_n && (bus_we || bus_re)) begin
      if (bus_we && bus_re) chk(0, "R2", "we and re together", 1, 0);
      if (q.size() == 0) chk(0, "R8", "unexpected bus access", bus_addr, 0);
      else begin
        op_t o;
        o = q.pop_front();
        chk(o.we == bus_we && o.a == bus_addr, "R2", "access kind/addr",
            {bus_we, bus_addr}, {o.we, o.a});
        if (o.we) chk(o.d == bus_wdata, "R2 R7", "write data", bus_wdata, o.d);
      end
    end
  end

  task automatic load_table;
    t_off = '{8'h00,8'h02,8'h03,8'h04,8'h05,8'h06,8'h07,8'h08,8'h09,8'h0a,8'h10,8'h11,8'h19,8'h1e,8'h1f};
    t_ro  = '{16'h0000,16'hffff,16'hffff,16'h0000,16'hefff,16'h0001,16'h0800,16'hffff,
              16'h0000,16'h7c00,16'h0000,16'h3300,16'h001f,16'h0000,16'h0000};
    t_rw  = '{16'h7180,16'h0000,16'h0000,16'hffff,16'h0000,16'h0000,16'hb7ff,16'h0000,
              16'hff00,16'h0000,16'hffbf,16'h0000,16'h0000,16'hffff,16'hffff};
  endtask

  // clean bank: masked bits behave, bits in neither mask are writable (R6)
  task automatic clean_bank;
    for (int k = 0; k < 32; k++) begin cfg_val[k] = 16'hA5C3 ^ {k[7:0], k[7:0]}; cfg_wm[k] = 16'h0; end
    for (int i = 0; i < NE; i++) cfg_wm[t_off[i]] = t_rw[i] | ~(t_ro[i] | t_rw[i]);
  endtask

  function automatic logic [15:0] wr(input logic [15:0] v, wm, d);
    return (v & ~wm) | (d & wm);
  endfunction

  task automatic judge(input logic [15:0] r, o, ro, rw, input bit one,
                       output bit err, output logic [1:0] code, output int bn);
    err = 0; code = 0; bn = 0;
    for (int b = 0; b < 16 && !err; b++)
      if (ro[b] && r[b] != o[b]) begin err = 1; bn = b; code = one ? 2'd1 : 2'd0; end
    for (int b = 0; b < 16 && !err; b++)
      if (rw[b] && r[b] != one) begin err = 1; bn = b; code = one ? 2'd3 : 2'd2; end
  endtask

  task automatic predict;
    logic [15:0] m[32];
    bit err; logic [1:0] c; int bn;
    q.delete();
    e_pass = 1; e_off = 0; e_bit = 0; e_code = 0;
    for (int k = 0; k < 32; k++) m[k] = cfg_val[k];
    for (int i = 0; i < NE && e_pass; i++) begin
      logic [7:0] a; logic [15:0] o;
      a = t_off[i]; o = m[a];
      q.push_back('{0, a, 16'h0});
      q.push_back('{1, a, 16'h0000});
      m[a] = wr(m[a], cfg_wm[a], 16'h0000);
      q.push_back('{0, a, 16'h0});
      judge(m[a], o, t_ro[i], t_rw[i], 0, err, c, bn);
      if (!err) begin
        q.push_back('{1, a, 16'hffff});
        m[a] = wr(m[a], cfg_wm[a], 16'hffff);
        q.push_back('{0, a, 16'h0});
        judge(m[a], o, t_ro[i], t_rw[i], 1, err, c, bn);
      end
      if (err) begin e_pass = 0; e_off = a; e_bit = bn; e_code = c; end
      q.push_back('{1, a, o});
      m[a] = wr(m[a], cfg_wm[a], o);
    end
  endtask

  task automatic run(input string name, input bit poke_busy,
                     input bit x_pass, input logic [7:0] x_off, input int x_bit, input int x_code);
    int n;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    predict();
    chk(e_pass == x_pass && (x_pass || (e_off == x_off && e_bit == x_bit && e_code == 2'(x_code))),
        "R4 R5", {name, " bench prediction"}, e_code, x_code);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R1", {name, " busy after start"}, {busy, done}, 2'b10);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy == 1'b1 && done == 1'b0, "R10", {name, " start while busy"}, {busy, done}, 2'b10);
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R8", {name, " run finished"}, done, 1);
    chk(pass == x_pass, "R9", {name, " pass"}, pass, x_pass);
    if (!x_pass) begin
      chk(fail_offset == x_off, "R8", {name, " fail_offset"}, fail_offset, x_off);
      chk(fail_bit == BW'(x_bit), "R8", {name, " fail_bit"}, fail_bit, x_bit);
      chk(fail_code == 2'(x_code), (x_code < 2) ? "R4 R3" : "R5 R3", {name, " fail_code"}, fail_code, x_code);
    end
    chk(q.size() == 0, "R2", {name, " all predicted accesses seen"}, q.size(), 0);
    for (int k = 0; k < 32; k++)
      if (bval[k] != cfg_val[k]) chk(0, "R7", {name, " bank restored"}, bval[k], cfg_val[k]);
    checks++;
    repeat (6) @(negedge clk);
    chk(done == 1'b1 && pass == x_pass && !busy, "R9", {name, " outcome held"}, {done, pass}, {1'b1, x_pass});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    load_table();
    clean_bank();
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0, "R1", "reset state", {busy, done, pass}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_we && !bus_re, "R1", "idle bus after reset", {bus_we, bus_re}, 0);

    // R6 R10: clean bank, unmasked bits writable, stray start mid-run
    run("clean", 1, 1, 0, 0, 0);

    // R4: read-only bit 11 of 0x07 writable (orig 1), plus read/write bit 0 stuck at 1
    clean_bank();
    cfg_wm[8'h07] = cfg_wm[8'h07] | 16'h0800;
    cfg_wm[8'h07] = cfg_wm[8'h07] & ~16'h0001;
    cfg_val[8'h07] = cfg_val[8'h07] | 16'h0801;
    run("ro_zero", 0, 0, 8'h07, 11, 0);

    // R4: read-only bit 12 of 0x0a writable with orig 0
    clean_bank();
    cfg_wm[8'h0a] = cfg_wm[8'h0a] | 16'h1000;
    cfg_val[8'h0a] = cfg_val[8'h0a] & ~16'h1000;
    run("ro_one", 0, 0, 8'h0a, 12, 1);

    // R5: read/write bit 5 of 0x04 stuck at 1
    clean_bank();
    cfg_wm[8'h04] = cfg_wm[8'h04] & ~16'h0020;
    cfg_val[8'h04] = cfg_val[8'h04] | 16'h0020;
    run("rw_clr", 0, 0, 8'h04, 5, 2);

    // R5: read/write bit 3 of 0x10 stuck at 0
    clean_bank();
    cfg_wm[8'h10] = cfg_wm[8'h10] & ~16'h0008;
    cfg_val[8'h10] = cfg_val[8'h10] & ~16'h0008;
    run("rw_set", 0, 0, 8'h10, 3, 3);

    // R9 R1: a clean rerun after a failure clears the old verdict
    clean_bank();
    run("rerun", 0, 1, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule